// File: doc/BRIEF.md
# Destination Address Hash Filter Table

This block keeps the station address table that a receive filter consults for destination MAC addresses. The table holds 2048 entries of 64 bits in an internal synchronous RAM. A 48-bit address is reduced to an 11-bit home slot by a fixed hash: the bits of every byte are mirrored, and then a few address fields are folded together with XOR. Collisions are handled by open addressing. The search starts at the home slot, moves forward one slot at a time, and wraps from the top slot back to slot 0. It gives up after a parameterised number of slots.

Commands arrive one at a time over a valid/ready request channel. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the block is idle. Each command is answered on a valid/ready response channel. Back-pressure is allowed there: once `rsp_valid` rises, the response fields hold steady until the edge where `rsp_ready` is seen high, and no new command is taken before then. The commands are lookup, add, delete and clear. An add either writes a new entry or refreshes a matching one. A clear wipes the whole table, one slot per cycle.

Top module: `mac_hash_table`

## Requirements
- R1: While reset is asserted, and after it is released, the block sweeps every slot to zero. During the sweep `busy` is high and `cmd_ready` and `rsp_valid` are low. The sweep lasts exactly 2048 cycles counted from the release, and then `cmd_ready` rises and no response is produced.
- R2: The home slot is computed as follows. The 48-bit address is split into H = bits 47:32 and L = bits 31:0. The bit order inside every byte of H and L is reversed. The fields are f0 = L[7:2], f1 = {L[14:8], L[1:0]}, f2 = L[23:15] and f3 = {H[0], L[31:24]}. The slot is the low 11 bits of ({f0, 9'b0} | (f1 ^ f2 ^ f3)). An add into an empty neighbourhood reports that slot.
- R3: An entry stores a valid flag in bit 0, a skip flag in bit 1 and a receive-destination flag in bit 2, with the address packed above them. Two entries are the same address when all bits except bits 2:0 match. Adding an address that is already present overwrites its flags in the same slot.
- R4: The search visits home, home+1, home+2 and so on, and the slot after 0x7FF is 0x000.
- R5: The search examines at most HOPS slots (default 12). When an add finds neither a free slot nor its own address among them, it answers status 2'b10 (full) and changes no entry. Every non-clear command answers within 2*HOPS cycles of acceptance.
- R6: A lookup that finds its address answers status 2'b00 with that entry's skip and receive-destination flags and its slot. A lookup answers 2'b01 (miss) with the flags and slot at zero when it first meets a free slot, or when the hop limit is used up. A free slot ends the search even if the address sits further on.
- R7: A delete that finds its address zeroes that entry. A delete that does not find it changes nothing. Both answer status 2'b00.
- R8: A clear command writes zero to all 2048 slots, one per cycle. `busy` stays high for exactly 2048 cycles after acceptance, and then the block answers status 2'b00.
- R9: The command codes are 2'b00 lookup, 2'b01 add, 2'b10 delete and 2'b11 clear. One command is in flight at a time. `cmd_ready` is low from acceptance until the response is taken, and status 2'b11 is never produced. A response that is held back keeps all its fields stable. An add or a delete reports the slot it wrote, or slot 0 if it wrote nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | Command code |
| cmd_mac | input | 48 | Address, first transmitted byte in bits 47:40 |
| cmd_skip | input | 1 | Skip flag stored by an add |
| cmd_rdst | input | 1 | Receive-destination flag stored by an add |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_status | output | 2 | 00 ok/hit, 01 miss, 10 full |
| rsp_slot | output | IDX_W | Slot written or matched |
| rsp_skip | output | 1 | Skip flag of a lookup hit |
| rsp_rdst | output | 1 | Receive-destination flag of a lookup hit |
| busy | output | 1 | Sweep or search in progress |

## Verification
The properties watch the protocol every cycle. They check that a held response stays stable and that only one command is in flight. They check that a response and `busy` never overlap, that the status code stays legal, and that a miss carries zeroed fields. A latency counter bounds every search by the hop limit. Other behaviour depends on table contents, which only the bench's scenarios can show: the exact hash slot, wrap past 0x7FF, and a search that stops at a hole left by a delete. The same holds for the table-full refusal at the twelfth neighbour, flag refresh on a repeated add, and the sweep length. The bench checks all of these against its own model of the table.

// File: rtl/mht_pkg.sv
package mht_pkg;
  localparam logic [1:0] OP_LOOKUP = 2'b00;
  localparam logic [1:0] OP_ADD    = 2'b01;
  localparam logic [1:0] OP_DEL    = 2'b10;
  localparam logic [1:0] OP_CLEAR  = 2'b11;

  localparam logic [1:0] ST_OK   = 2'b00;
  localparam logic [1:0] ST_MISS = 2'b01;
  localparam logic [1:0] ST_FULL = 2'b10;

  localparam int ENTRY_W = 64;
  localparam int FLAG_VALID = 0;
  localparam int FLAG_SKIP  = 1;
  localparam int FLAG_RDST  = 2;
  localparam int KEY_LSB    = 3;

  typedef enum logic [2:0] {
    S_SWEEP, S_IDLE, S_READ, S_TEST, S_REPLY
  } mht_state_e;
endpackage

// File: rtl/mht_hash.sv
module mht_hash #(
  parameter int IDX_W = 11
) (
  input  logic [47:0]      mac,
  output logic [IDX_W-1:0] idx
);
  localparam int RAW_W = 15;
  localparam int BYTES = 6;

  logic [47:0] mirr;
  logic [15:0] hi_part;
  logic [31:0] lo_part;
  logic [5:0]  g0;
  logic [8:0]  g1, g2, g3;
  logic [RAW_W-1:0] raw;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign mirr[b*8 + i] = mac[b*8 + 7 - i];
    end
  end

  assign hi_part = mirr[47:32];
  assign lo_part = mirr[31:0];
  assign g0 = lo_part[7:2];
  assign g1 = {lo_part[14:8], lo_part[1:0]};
  assign g2 = lo_part[23:15];
  assign g3 = {hi_part[0], lo_part[31:24]};
  assign raw = {g0, 9'b0} | {6'b0, (g1 ^ g2 ^ g3)};
  assign idx = raw[IDX_W-1:0];

  logic unused_hash_bits;
  assign unused_hash_bits = ^{raw, hi_part[15:1]};
endmodule

// File: rtl/mht_codec.sv
module mht_codec
  import mht_pkg::*;
(
  input  logic [47:0]        mac,
  input  logic               skip,
  input  logic               rdst,
  output logic [ENTRY_W-1:0] word
);
  logic [31:0] w_lo, w_hi;

  always_comb begin
    w_lo = '0;
    w_lo[FLAG_VALID] = 1'b1;
    w_lo[FLAG_SKIP]  = skip;
    w_lo[FLAG_RDST]  = rdst;
    w_lo[6:3]   = mac[43:40];
    w_lo[10:7]  = mac[47:44];
    w_lo[14:11] = mac[35:32];
    w_lo[18:15] = mac[39:36];
    w_lo[22:19] = mac[27:24];
    w_lo[26:23] = mac[31:28];
    w_lo[30:27] = mac[19:16];
    w_lo[31]    = mac[20];
    w_hi = '0;
    w_hi[2:0]   = mac[23:21];
    w_hi[6:3]   = mac[11:8];
    w_hi[10:7]  = mac[15:12];
    w_hi[14:11] = mac[3:0];
    w_hi[18:15] = mac[7:4];
  end

  assign word = {w_hi, w_lo};
endmodule

// File: rtl/mht_ram.sv
module mht_ram #(
  parameter int AW = 11,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[addr] <= wdata;
    else if (re)
      rdata <= mem[addr];
  end
endmodule

// File: rtl/mht_ctrl.sv
module mht_ctrl
  import mht_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int HOPS  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [IDX_W-1:0]   cmd_home,
  input  logic [ENTRY_W-1:0] cmd_word,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [1:0]         rsp_status,
  output logic [IDX_W-1:0]   rsp_slot,
  output logic               rsp_skip,
  output logic               rsp_rdst,
  output logic               busy,
  output logic               ram_we,
  output logic               ram_re,
  output logic [IDX_W-1:0]   ram_addr,
  output logic [ENTRY_W-1:0] ram_wdata,
  input  logic [ENTRY_W-1:0] ram_rdata
);
  localparam int HOP_W = $clog2(HOPS + 1);
  localparam logic [HOP_W-1:0] HOP_LAST = HOP_W'(HOPS - 1);

  mht_state_e         state;
  logic [1:0]         op_q;
  logic [ENTRY_W-1:0] key_q;
  logic [IDX_W-1:0]   probe_q;
  logic [IDX_W-1:0]   sweep_q;
  logic [HOP_W-1:0]   hop_q;
  logic               sweep_ack_q;

  logic slot_free, slot_same, hop_done, ends, do_write;

  assign slot_free = !ram_rdata[FLAG_VALID];
  assign slot_same = ram_rdata[FLAG_VALID]
                   && (ram_rdata[31:KEY_LSB] == key_q[31:KEY_LSB])
                   && (ram_rdata[63:32] == key_q[63:32]);
  assign hop_done  = (hop_q == HOP_LAST);
  assign ends      = slot_free || slot_same || hop_done;
  assign do_write  = (state == S_TEST)
                   && (((op_q == OP_ADD) && (slot_free || slot_same))
                       || ((op_q == OP_DEL) && slot_same));

  always_comb begin
    ram_we    = 1'b0;
    ram_re    = 1'b0;
    ram_addr  = probe_q;
    ram_wdata = '0;
    case (state)
      S_SWEEP: begin
        ram_we   = 1'b1;
        ram_addr = sweep_q;
      end
      S_READ: ram_re = 1'b1;
      S_TEST: begin
        ram_we    = do_write;
        ram_wdata = (op_q == OP_DEL) ? '0 : key_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_SWEEP;
      op_q        <= OP_LOOKUP;
      key_q       <= '0;
      probe_q     <= '0;
      sweep_q     <= '0;
      hop_q       <= '0;
      sweep_ack_q <= 1'b0;
      rsp_status  <= ST_OK;
      rsp_slot    <= '0;
      rsp_skip    <= 1'b0;
      rsp_rdst    <= 1'b0;
    end else begin
      case (state)
        S_SWEEP: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == {IDX_W{1'b1}}) begin
            rsp_status <= ST_OK;
            rsp_slot   <= '0;
            rsp_skip   <= 1'b0;
            rsp_rdst   <= 1'b0;
            state      <= sweep_ack_q ? S_REPLY : S_IDLE;
          end
        end
        S_IDLE: begin
          if (cmd_valid) begin
            op_q    <= cmd_op;
            key_q   <= cmd_word;
            probe_q <= cmd_home;
            hop_q   <= '0;
            sweep_q <= '0;
            if (cmd_op == OP_CLEAR) begin
              sweep_ack_q <= 1'b1;
              state       <= S_SWEEP;
            end else begin
              state <= S_READ;
            end
          end
        end
        S_READ: state <= S_TEST;
        S_TEST: begin
          if (ends) begin
            state    <= S_REPLY;
            rsp_skip <= 1'b0;
            rsp_rdst <= 1'b0;
            rsp_slot <= '0;
            rsp_status <= ST_OK;
            if (slot_same || ((op_q == OP_ADD) && slot_free))
              rsp_slot <= probe_q;
            case (op_q)
              OP_LOOKUP: begin
                if (slot_same) begin
                  rsp_skip <= ram_rdata[FLAG_SKIP];
                  rsp_rdst <= ram_rdata[FLAG_RDST];
                end else begin
                  rsp_status <= ST_MISS;
                end
              end
              OP_ADD: if (!slot_free && !slot_same) rsp_status <= ST_FULL;
              default: ;
            endcase
          end else begin
            probe_q <= probe_q + 1'b1;
            hop_q   <= hop_q + 1'b1;
            state   <= S_READ;
          end
        end
        S_REPLY: begin
          if (rsp_ready) begin
            sweep_ack_q <= 1'b0;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_REPLY);
  assign busy      = (state == S_SWEEP) || (state == S_READ) || (state == S_TEST);
endmodule

// File: rtl/mac_hash_table.sv
module mac_hash_table
  import mht_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int HOPS  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [47:0]      cmd_mac,
  input  logic             cmd_skip,
  input  logic             cmd_rdst,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_status,
  output logic [IDX_W-1:0] rsp_slot,
  output logic             rsp_skip,
  output logic             rsp_rdst,
  output logic             busy
);
  logic [IDX_W-1:0]   home;
  logic [ENTRY_W-1:0] word;
  logic               ram_we, ram_re;
  logic [IDX_W-1:0]   ram_addr;
  logic [ENTRY_W-1:0] ram_wdata, ram_rdata;

  mht_hash #(.IDX_W(IDX_W)) u_hash (
    .mac (cmd_mac),
    .idx (home)
  );

  mht_codec u_codec (
    .mac  (cmd_mac),
    .skip (cmd_skip),
    .rdst (cmd_rdst),
    .word (word)
  );

  mht_ctrl #(.IDX_W(IDX_W), .HOPS(HOPS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_home   (home),
    .cmd_word   (word),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_status (rsp_status),
    .rsp_slot   (rsp_slot),
    .rsp_skip   (rsp_skip),
    .rsp_rdst   (rsp_rdst),
    .busy       (busy),
    .ram_we     (ram_we),
    .ram_re     (ram_re),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata)
  );

  mht_ram #(.AW(IDX_W), .DW(ENTRY_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );
endmodule

// File: rtl/mht_checker.sv
module mht_checker #(
  parameter int IDX_W = 11,
  parameter int HOPS  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [1:0]       rsp_status,
  input logic [IDX_W-1:0] rsp_slot,
  input logic             rsp_skip,
  input logic             rsp_rdst,
  input logic             busy
);
  localparam int LAT_W = $clog2(2*HOPS + 4);

  logic             pend, pend_sweep;
  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_sweep <= 1'b0;
      lat        <= '0;
    end else if (cmd_valid && cmd_ready) begin
      pend       <= 1'b1;
      pend_sweep <= (cmd_op == 2'b11);
      lat        <= LAT_W'(1);
    end else if (rsp_valid && rsp_ready) begin
      pend <= 1'b0;
    end else if (pend && !rsp_valid && (lat != {LAT_W{1'b1}})) begin
      lat <= lat + 1'b1;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status)
      && $stable(rsp_slot) && $stable(rsp_skip) && $stable(rsp_rdst));

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R9
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready && !busy);

  // R9
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'b11);

  // R6
  miss_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 2'b01 |-> !rsp_skip && !rsp_rdst && rsp_slot == '0);

  // R5
  hop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !pend_sweep && !rsp_valid |-> int'(lat) <= 2*HOPS);

  // R8
  clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'b11 |=> busy);

  // R1
  rsp_after_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(busy));
endmodule

bind mac_hash_table mht_checker #(.IDX_W(IDX_W), .HOPS(HOPS)) u_mht_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_status (rsp_status),
  .rsp_slot   (rsp_slot),
  .rsp_skip   (rsp_skip),
  .rsp_rdst   (rsp_rdst),
  .busy       (busy)
);

// File: tb/test_mac_hash_table.sv
`timescale 1ns/1ps
module test_mac_hash_table;
  localparam int IDX_W = 11;
  localparam int HOPS  = 12;
  localparam int SLOTS = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [47:0] cmd_mac = '0;
  logic cmd_skip = 1'b0, cmd_rdst = 1'b0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [1:0] rsp_status;
  logic [IDX_W-1:0] rsp_slot;
  logic rsp_skip, rsp_rdst, busy;

  always #4 clk = ~clk;

  mac_hash_table #(.IDX_W(IDX_W), .HOPS(HOPS)) i_mac_hash_table (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  bit          m_v   [SLOTS];
  logic [47:0] m_mac [SLOTS];
  bit          m_sk  [SLOTS];
  bit          m_rd  [SLOTS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] ref_home(input logic [47:0] m);
    logic [47:0] r;
    logic [14:0] v;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) r[b*8+i] = m[b*8+7-i];
    v = {r[7:2], 9'h000};
    v = v | {6'h00, {r[14:8], r[1:0]} ^ r[23:15] ^ {r[32], r[31:24]}};
    return v[10:0];
  endfunction

  function automatic logic [47:0] mac_for_home(input logic [10:0] tgt);
    logic [47:0] m;
    do begin
      m = {$urandom, $urandom};
      m[47:40] = 8'h00;
      m[3:0] = 4'h0;
    end while (ref_home(m) != tgt);
    return m;
  endfunction

  function automatic logic [47:0] variant(input logic [47:0] base, input int k);
    logic [47:0] m = base;
    m[47:40] = k[7:0];
    return m;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < SLOTS; i++) begin
      m_v[i] = 0; m_mac[i] = '0; m_sk[i] = 0; m_rd[i] = 0;
    end
  endtask

  task automatic model_exec(input logic [1:0] op, input logic [47:0] mac,
                            input bit sk, input bit rd,
                            output logic [1:0] st, output logic [10:0] slot,
                            output bit osk, output bit ord);
    int idx = 0;
    bit free_f = 0, same_f = 0;
    int home = int'(ref_home(mac));
    st = 2'b00; slot = '0; osk = 0; ord = 0;
    if (op == 2'b11) begin
      model_clear();
      return;
    end
    for (int h = 0; h < HOPS; h++) begin
      idx = (home + h) % SLOTS;
      if (!m_v[idx]) begin free_f = 1; break; end
      if (m_mac[idx] == mac) begin same_f = 1; break; end
    end
    case (op)
      2'b00: if (same_f) begin
               slot = idx[10:0]; osk = m_sk[idx]; ord = m_rd[idx];
             end else st = 2'b01;
      2'b01: if (same_f || free_f) begin
               slot = idx[10:0];
               m_v[idx] = 1; m_mac[idx] = mac; m_sk[idx] = sk; m_rd[idx] = rd;
             end else st = 2'b10;
      default: if (same_f) begin
               slot = idx[10:0];
               m_v[idx] = 0; m_mac[idx] = '0; m_sk[idx] = 0; m_rd[idx] = 0;
             end
    endcase
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [47:0] mac,
                         input bit sk, input bit rd, input int hold, input string req);
    logic [1:0] e_st; logic [10:0] e_slot; bit e_sk, e_rd;
    logic [14:0] got, exp;
    int busy_n = 0;
    model_exec(op, mac, sk, rd, e_st, e_slot, e_sk, e_rd);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_mac = mac; cmd_skip = sk; cmd_rdst = rd;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R9", "ready after accept", cmd_ready, 0);
    while (!rsp_valid) begin
      if (busy) busy_n++;
      @(negedge clk);
    end
    if (op == 2'b11) chk(busy_n == SLOTS, "R8", "clear busy cycles", busy_n, SLOTS);
    exp = {e_st, e_slot, e_sk, e_rd};
    got = {rsp_status, rsp_slot, rsp_skip, rsp_rdst};
    chk(got == exp, req, "response {status,slot,skip,rdst}", got, exp);
    for (int j = 0; j < hold; j++) begin
      @(negedge clk);
      chk(rsp_valid && ({rsp_status, rsp_slot, rsp_skip, rsp_rdst} == exp), "R9",
          "held response", {rsp_valid, rsp_status, rsp_slot, rsp_skip, rsp_rdst},
          {1'b1, exp});
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, w, g1, g2, g3;
    logic [47:0] pool [48];
    int cnt;
    void'($urandom(32'd20240611));
    model_clear();

    // R1: reset state and post-reset sweep
    repeat (3) @(negedge clk);
    chk(busy && !cmd_ready && !rsp_valid, "R1", "state in reset",
        {busy, cmd_ready, rsp_valid}, 3'b100);
    rst_n = 1;
    cnt = 0;
    while (busy) begin
      chk(!cmd_ready && !rsp_valid, "R1", "sweep outputs", {cmd_ready, rsp_valid}, 0);
      cnt++;
      @(negedge clk);
    end
    chk(cnt == SLOTS, "R1", "sweep length", cnt, SLOTS);
    chk(cmd_ready && !rsp_valid, "R1", "idle after sweep", {cmd_ready, rsp_valid}, 2'b10);

    // R6: lookup in empty table misses
    run_cmd(2'b00, 48'h0011_2233_4455, 0, 0, 0, "R6");
    // R2: home slots of assorted addresses
    for (int i = 0; i < 6; i++) begin
      a = {$urandom, $urandom};
      run_cmd(2'b01, a, i[0], i[1], 0, "R2");
    end
    run_cmd(2'b01, 48'hFFFF_FFFF_FFFF, 1, 1, 0, "R2");
    run_cmd(2'b01, 48'h0000_0000_0001, 0, 1, 0, "R2");

    // R3: repeated add refreshes flags in place
    a = 48'h02AB_CD12_3456;
    run_cmd(2'b01, a, 1, 0, 0, "R3");
    run_cmd(2'b01, a, 0, 1, 2, "R3");
    run_cmd(2'b00, a, 0, 0, 1, "R3");

    // R4: wrap from 0x7FF to 0x000
    g1 = mac_for_home(11'h7FF);
    for (int k = 1; k <= 3; k++) run_cmd(2'b01, variant(g1, k), 0, 1, 0, "R4");
    run_cmd(2'b00, variant(g1, 3), 0, 0, 0, "R4");
    // R6: hole at slot 0 ends the search before slot 1
    run_cmd(2'b10, variant(g1, 2), 0, 0, 0, "R7");
    run_cmd(2'b00, variant(g1, 3), 0, 0, 0, "R6");
    run_cmd(2'b00, variant(g1, 1), 0, 0, 0, "R6");

    // R5: hop limit
    run_cmd(2'b11, '0, 0, 0, 0, "R8");
    g2 = mac_for_home(11'h123);
    for (int k = 1; k <= HOPS; k++) run_cmd(2'b01, variant(g2, k), k[0], 0, 0, "R5");
    run_cmd(2'b01, variant(g2, 50), 1, 1, 1, "R5");
    run_cmd(2'b00, variant(g2, 50), 0, 0, 0, "R5");
    run_cmd(2'b00, variant(g2, HOPS), 0, 0, 0, "R6");
    // R7: delete of absent address is a no-op
    run_cmd(2'b10, variant(g2, 77), 0, 0, 0, "R7");
    for (int k = 1; k <= HOPS; k++) run_cmd(2'b00, variant(g2, k), 0, 0, 0, "R7");
    run_cmd(2'b10, variant(g2, 5), 0, 0, 0, "R7");
    run_cmd(2'b00, variant(g2, 5), 0, 0, 0, "R7");
    run_cmd(2'b01, variant(g2, 50), 0, 1, 0, "R5");

    // R8: clear empties everything
    run_cmd(2'b11, '0, 0, 0, 3, "R8");
    run_cmd(2'b00, variant(g2, 1), 0, 0, 0, "R8");
    run_cmd(2'b00, a, 0, 0, 0, "R8");

    // random mix over clustered addresses
    g3 = mac_for_home(11'h7FA);
    for (int k = 0; k < 16; k++) begin
      pool[k]      = variant(g3, k + 1);
      pool[16 + k] = variant(g2, k + 1);
      pool[32 + k] = {$urandom, $urandom};
    end
    for (int n = 0; n < 320; n++) begin
      int r = $urandom_range(0, 99);
      int p = $urandom_range(0, 47);
      int hold = $urandom_range(0, 3);
      if (n == 160)      run_cmd(2'b11, '0, 0, 0, hold, "R8");
      else if (r < 40)   run_cmd(2'b01, pool[p], $urandom_range(0, 1) == 1,
                                 $urandom_range(0, 1) == 1, hold, "R5");
      else if (r < 72)   run_cmd(2'b00, pool[p], 0, 0, hold, "R6");
      else               run_cmd(2'b10, pool[p], 0, 0, hold, "R7");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule